// File: doc/BRIEF.md
# ROM Image Selection Sequencer

This block decides which of several stored ROM images a Z80-style host computer sees, and resets the host whenever that choice changes. The host therefore never runs code that has been replaced while it was executing. The block drives an image index that the memory side uses to pick an image. It also drives an active-low reset line to the host. Its inputs are a clean, debounced push-button and a ready flag that rises once the block's own surroundings have come up.

From power-up the host is held in reset with image 0 selected. When the ready flag rises, the block holds the host in reset for a fixed pulse and then lets it run.

Each press of the button starts a switch in two steps:
1. The block shows a dedicated banner image and resets the host so that the banner program runs.
2. After a timed interval it selects the next image in a fixed circular order and resets the host again.

The banner index lies outside the normal cycle. The reset pulse width and the banner interval are parameters given in clock cycles.

Top module: `rom_rotator`

## Requirements
- R1: While `por_n_i` is low, `image_o` is 0 and `host_rst_n_o` is 0.
- R2: After power-up, `host_rst_n_o` stays 0 for as long as `ready_i` has never been seen high. The button has no effect during this time, and `image_o` stays 0.
- R3: Once `ready_i` is seen high, `host_rst_n_o` stays 0 for exactly `RST_CYCLES` further clock cycles and then goes to 1.
- R4: Suppose the host is running a normal image and `button_i` rises (0 in one cycle, 1 in the next). Then `image_o` takes the value `BANNER_IDX`, and `host_rst_n_o` is 0 for exactly `RST_CYCLES` cycles.
- R5: After the banner reset is released, the banner runs with `host_rst_n_o` at 1 for exactly `BANNER_CYCLES` cycles. Then `image_o` moves to the next image and `host_rst_n_o` is 0 for exactly `RST_CYCLES` cycles.
- R6: Normal images follow the order 0, 1, …, `NUM_IMAGES`-1 and then wrap to 0. `image_o` is only ever a normal index or `BANNER_IDX`, and the banner is never chosen as the next image.
- R7: A rising edge of `button_i` during the banner interval is ignored. A button that is still held after a switch completes starts no further switch.
- R8: `image_o` changes only in a cycle in which `host_rst_n_o` is 0. A low reset pulse always lasts at least `RST_CYCLES` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| por_n_i | input | 1 | Active-low asynchronous power-on reset of the block |
| ready_i | input | 1 | High once the block may start the host |
| button_i | input | 1 | Debounced push-button level; a rising edge requests a switch |
| image_o | output | IDX_W | Index of the image presented to the host |
| host_rst_n_o | output | 1 | Active-low reset to the host |

## Verification
The assertions check on every cycle that:
- the index moves only while the host is held in reset;
- each reset pulse is at least the configured width;
- the host stays in reset before ready is first seen;
- the index never leaves the set of normal images plus the banner;
- the step out of the banner never lands on the banner.

Only the bench scenarios can show the exact pulse and banner lengths, the circular order with its wrap, and that presses during the banner or a held button are ignored. Each of these depends on a sequence of inputs over many cycles.

// File: rtl/rom_rotator.sv
module rom_rotator #(
  parameter int NUM_IMAGES    = 4,
  parameter int IDX_W         = 3,
  parameter int BANNER_IDX    = 7,
  parameter int RST_CYCLES    = 16,
  parameter int BANNER_CYCLES = 100_000_000
) (
  input  logic             clk_i,
  input  logic             por_n_i,
  input  logic             ready_i,
  input  logic             button_i,
  output logic [IDX_W-1:0] image_o,
  output logic             host_rst_n_o
);
  localparam int MAXC  = (RST_CYCLES > BANNER_CYCLES) ? RST_CYCLES : BANNER_CYCLES;
  localparam int CNT_W = $clog2(MAXC) + 1;
  localparam logic [IDX_W-1:0] LAST   = IDX_W'(NUM_IMAGES - 1);
  localparam logic [IDX_W-1:0] BANNER = IDX_W'(BANNER_IDX);
  localparam logic [CNT_W-1:0] RST_END = CNT_W'(RST_CYCLES - 1);
  localparam logic [CNT_W-1:0] BAN_END = CNT_W'(BANNER_CYCLES - 1);

  typedef enum logic [1:0] {S_WAIT, S_PULSE, S_RUN, S_BANNER} state_t;

  state_t           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] img_q, nxt_q;
  logic             btn_q, to_banner_q;
  logic             press;

  assign press        = button_i & ~btn_q;
  assign image_o      = img_q;
  assign host_rst_n_o = (state_q == S_RUN) || (state_q == S_BANNER);

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      state_q     <= S_WAIT;
      cnt_q       <= '0;
      img_q       <= '0;
      nxt_q       <= '0;
      btn_q       <= 1'b0;
      to_banner_q <= 1'b0;
    end else begin
      btn_q <= button_i;
      case (state_q)
        S_WAIT: begin
          cnt_q <= '0;
          if (ready_i) state_q <= S_PULSE;
        end
        S_PULSE: begin
          if (cnt_q == RST_END) begin
            cnt_q   <= '0;
            state_q <= to_banner_q ? S_BANNER : S_RUN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_RUN: begin
          if (press) begin
            nxt_q       <= (img_q == LAST) ? '0 : img_q + 1'b1;
            img_q       <= BANNER;
            to_banner_q <= 1'b1;
            cnt_q       <= '0;
            state_q     <= S_PULSE;
          end
        end
        S_BANNER: begin
          if (cnt_q == BAN_END) begin
            img_q       <= nxt_q;
            to_banner_q <= 1'b0;
            cnt_q       <= '0;
            state_q     <= S_PULSE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= S_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/rom_rotator_checker.sv
module rom_rotator_checker #(
  parameter int NUM_IMAGES = 4,
  parameter int IDX_W      = 3,
  parameter int BANNER_IDX = 7,
  parameter int RST_CYCLES = 16
) (
  input logic             clk_i,
  input logic             por_n_i,
  input logic             ready_i,
  input logic [IDX_W-1:0] image_o,
  input logic             host_rst_n_o
);
  logic        seen_ready_q;
  logic [31:0] low_run_q;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      seen_ready_q <= 1'b0;
      low_run_q    <= '0;
    end else begin
      if (ready_i) seen_ready_q <= 1'b1;
      if (host_rst_n_o) low_run_q <= '0;
      else if (low_run_q < 32'(RST_CYCLES)) low_run_q <= low_run_q + 1;
    end
  end

  assert_index_moves_in_reset_R8: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (image_o != $past(image_o)) |-> !host_rst_n_o);

  assert_pulse_width_R8: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $rose(host_rst_n_o) |-> (low_run_q >= 32'(RST_CYCLES)));

  assert_hold_until_ready_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (!seen_ready_q && !ready_i) |-> !host_rst_n_o);

  assert_legal_index_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (32'(image_o) < 32'(NUM_IMAGES)) || (32'(image_o) == 32'(BANNER_IDX)));

  assert_banner_not_next_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
    ((32'($past(image_o)) == 32'(BANNER_IDX)) && (image_o != $past(image_o)))
      |-> (32'(image_o) < 32'(NUM_IMAGES)));
endmodule

bind rom_rotator rom_rotator_checker #(
  .NUM_IMAGES(NUM_IMAGES), .IDX_W(IDX_W), .BANNER_IDX(BANNER_IDX), .RST_CYCLES(RST_CYCLES)
) chk_i (
  .clk_i(clk_i), .por_n_i(por_n_i), .ready_i(ready_i),
  .image_o(image_o), .host_rst_n_o(host_rst_n_o)
);

// File: tb/rom_rotator_tb_top.sv
module rom_rotator_tb_top;
  localparam int NUM = 4;
  localparam int IW  = 3;
  localparam int BAN = 7;
  localparam int RC  = 16;
  localparam int BC  = 40;

  logic clk = 1'b0;
  logic por_n = 1'b0, ready = 1'b0, button = 1'b0;
  logic [IW-1:0] image;
  logic host_rst_n;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rom_rotator #(.NUM_IMAGES(NUM), .IDX_W(IW), .BANNER_IDX(BAN),
                .RST_CYCLES(RC), .BANNER_CYCLES(BC)) dut_i (
    .clk_i(clk), .por_n_i(por_n), .ready_i(ready), .button_i(button),
    .image_o(image), .host_rst_n_o(host_rst_n));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic test_power_up();
    @(negedge clk); @(negedge clk);
    check(image == 0, "R1 index in por", int'(image), 0);
    check(host_rst_n == 0, "R1 host reset in por", int'(host_rst_n), 0);
    por_n = 1'b1;
    repeat (10) tick();
    check(host_rst_n == 0, "R2 reset before ready", int'(host_rst_n), 0);
    button = 1'b1; repeat (3) tick(); button = 1'b0; repeat (3) tick();
    check(image == 0, "R2 button before ready", int'(image), 0);
    check(host_rst_n == 0, "R2 reset after button", int'(host_rst_n), 0);
  endtask

  task automatic test_ready();
    int n = 0;
    ready = 1'b1;
    forever begin
      tick();
      if (host_rst_n) break;
      n++;
    end
    check(n == RC, "R3 startup pulse width", n, RC);
    check(image == 0, "R3 image after start", int'(image), 0);
  endtask

  task automatic do_switch(input int exp_next);
    int n = 0, bn = 1;
    bit bad = 0;
    button = 1'b1;
    forever begin
      tick();
      if (host_rst_n) break;
      n++;
      if (image != BAN) bad = 1;
    end
    check(n == RC, "R4 banner reset width", n, RC);
    check(!bad && image == BAN, "R4 banner index", int'(image), BAN);
    bad = 0;
    forever begin
      tick();
      if (bn == 2) button = 1'b0;
      if (bn == 4) button = 1'b1;
      if (!host_rst_n) break;
      bn++;
      if (image != BAN) bad = 1;
    end
    check(bn == BC, "R5 banner interval", bn, BC);
    check(!bad, "R7 press in banner ignored", 1, 0);
    check(image == IW'(exp_next), "R6 next image order", int'(image), exp_next);
    n = 1;
    forever begin
      tick();
      if (host_rst_n) break;
      n++;
    end
    check(n == RC, "R5 second reset width", n, RC);
    repeat (10) tick();
    check(image == IW'(exp_next) && host_rst_n, "R7 held button no switch", int'(image), exp_next);
    button = 1'b0;
    repeat (3) tick();
  endtask

  initial begin
    #(10 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_power_up();
    test_ready();
    do_switch(1);
    do_switch(2);
    do_switch(3);
    do_switch(0);
    do_switch(1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule